// File: doc/BRIEF.md
# Warp Thread-Group Mask Tracker

This block keeps the grouping of the threads of one warp into groups that run in lockstep. The warp has `NUM_THREADS` threads, and there are the same number of group slots. Each slot holds a valid flag, a process identifier, a program counter and a membership mask. Bit i of a mask is set when thread i of the warp belongs to that group. No two groups ever share a thread, so the number of slots is always enough.

A front end uses the block in three ways:
- It starts the warp as a single group.
- It reports each predicted fetch PC for one group. The block then folds into that group every other group that has reached the same PC in the same process.
- It reports mispredictions. The block moves the wrongly predicted threads into a group of their own at the corrected PC, and emits a kill mask so that the pipeline can remove those threads from instructions already in flight.

The block also keeps one sequence counter per thread. A fetch advances the counters of the fetched threads. After a split, the counters of the moved threads restart just after the branch's own sequence number.

Top module: `warp_group_tracker`

## Requirements
- R1: After reset, every slot is invalid with a zero mask, every sequence counter is zero and `killValid` is low.
- R2: A `startValid` strobe makes slot 0 valid with all threads in its mask (all ones), with `startPid` and `startPc`. All other slots become invalid and all sequence counters are cleared. This takes priority over the other strobes in the same cycle.
- R3: A prediction for a valid slot with no matching group sets that slot's PC to `predPc` and leaves its mask unchanged. It adds one to the sequence counter of each member thread. A prediction for an invalid slot changes nothing.
- R4: If another valid slot holds the same PC as `predPc` and the same process ID as the predicted slot, the predicted slot's mask becomes the OR of the two masks. The other slot becomes invalid with an empty mask. Every thread of the merged mask has its counter advanced by one.
- R5: A partial misprediction clears the bits of `mispMask AND groupMask` in the group. Those threads move to the lowest-numbered invalid slot, which gets the same process ID and PC `mispPc`. For each moved thread i, the counter becomes `mispSeq[i]+1`.
- R6: A total misprediction covers every thread of the group. It keeps the group in its slot, redirects the group's PC to `mispPc` and restarts the counters of its threads from `mispSeq`.
- R7: On the clock edge after an effective misprediction, `killValid` is high, `killMask` equals `mispMask AND groupMask`, and `killWarp` equals `warpId`. `killValid` stays high for one cycle only. A misprediction on an invalid slot, or one whose mask does not intersect the group, changes nothing and raises no kill.
- R8: When a split and a prediction arrive in the same cycle, the split is applied first. A prediction for the slot being split is dropped. Slots that the split modifies or creates are excluded from merging in that cycle.
- R9: Slot masks never overlap. A slot is valid exactly when its mask is non-empty. Once started, the union of all masks covers every thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warpId | input | WARP_W | Identifier of this warp, echoed with kills |
| startValid | input | 1 | Start the warp as a single group |
| startPid | input | PID_W | Process ID for the start group |
| startPc | input | PC_W | PC for the start group |
| predValid | input | 1 | Predicted fetch PC available for one group |
| predSlot | input | IDX_W | Slot that the prediction belongs to |
| predPc | input | PC_W | Predicted PC |
| mispValid | input | 1 | Misprediction report |
| mispSlot | input | IDX_W | Slot of the mispredicted group |
| mispMask | input | NUM_THREADS | Threads that mispredicted |
| mispPc | input | PC_W | Corrected PC |
| mispSeq | input | NUM_THREADS*SEQ_W | Branch sequence numbers, thread i at bits [i*SEQ_W +: SEQ_W] |
| slotValid | output | NUM_THREADS | Valid flag per slot |
| slotMask | output | NUM_THREADS*NUM_THREADS | Slot s mask at bits [s*NUM_THREADS +: NUM_THREADS] |
| slotPc | output | NUM_THREADS*PC_W | Slot s PC at bits [s*PC_W +: PC_W] |
| slotPid | output | NUM_THREADS*PID_W | Slot s process ID at bits [s*PID_W +: PID_W] |
| seqVec | output | NUM_THREADS*SEQ_W | Thread i counter at bits [i*SEQ_W +: SEQ_W] |
| killValid | output | 1 | Kill strobe |
| killMask | output | NUM_THREADS | Threads to clear from in-flight instructions |
| killWarp | output | WARP_W | Warp that the kill applies to |

## Verification
All results are registered once. Slot state, sequence counters and the kill outputs all reflect a strobe on the first rising edge after it is driven, and the kill strobe drops one edge later. The bench drives each strobe on a falling edge, lets exactly one rising edge pass, and compares at the following falling edge. The single-cycle width of the kill is confirmed one further cycle on. The tests carry a hand-computed model of the counters and masks from one scenario to the next, so a wrong merge or split shows up in later checks as well.

// File: rtl/wgt_pkg.sv
package wgt_pkg;
  typedef struct packed {
    logic startEn;
    logic splitEn;
    logic splitTotal;
    logic predEn;
  } wgtStrobes_t;
endpackage

// File: rtl/wgt_ctrl.sv
module wgt_ctrl
  import wgt_pkg::*;
#(
  parameter int M     = 4,
  parameter int PC_W  = 16,
  parameter int PID_W = 4,
  parameter int IDX_W = $clog2(M)
) (
  input  logic              startValid,
  input  logic              predValid,
  input  logic [IDX_W-1:0]  predSlot,
  input  logic [PC_W-1:0]   predPc,
  input  logic              mispValid,
  input  logic [IDX_W-1:0]  mispSlot,
  input  logic [M-1:0]      mispMask,
  input  logic [M-1:0]      curValid,
  input  logic [M-1:0]      curMask [M],
  input  logic [PC_W-1:0]   curPc   [M],
  input  logic [PID_W-1:0]  curPid  [M],
  output wgtStrobes_t       strb,
  output logic [IDX_W-1:0]  newSlot,
  output logic [M-1:0]      effMask,
  output logic [M-1:0]      mergeHit
);
  logic [M-1:0]     grpMask;
  logic [M-1:0]     touched;
  logic [IDX_W-1:0] freeSlot;
  logic             found;

  always_comb begin
    grpMask = curMask[mispSlot];
    effMask = (mispValid && curValid[mispSlot]) ? (mispMask & grpMask) : '0;
    strb.startEn    = startValid;
    strb.splitEn    = !startValid && (|effMask);
    strb.splitTotal = (effMask == grpMask);
    // lowest free slot receives a spawned group
    freeSlot = '0;
    found    = 1'b0;
    for (int s = 0; s < M; s++) begin
      if (!curValid[s] && !found) begin
        freeSlot = IDX_W'(s);
        found    = 1'b1;
      end
    end
    newSlot = strb.splitTotal ? mispSlot : freeSlot;
    touched = '0;
    if (strb.splitEn) begin
      touched[mispSlot] = 1'b1;
      touched[newSlot]  = 1'b1;
    end
    strb.predEn = !startValid && predValid && curValid[predSlot] &&
                  !(strb.splitEn && (predSlot == mispSlot));
    for (int s = 0; s < M; s++) begin
      mergeHit[s] = strb.predEn && (IDX_W'(s) != predSlot) && curValid[s] &&
                    !touched[s] && (curPc[s] == predPc) &&
                    (curPid[s] == curPid[predSlot]);
    end
  end
endmodule

// File: rtl/wgt_dp.sv
module wgt_dp
  import wgt_pkg::*;
#(
  parameter int M      = 4,
  parameter int PC_W   = 16,
  parameter int PID_W  = 4,
  parameter int SEQ_W  = 6,
  parameter int WARP_W = 2,
  parameter int IDX_W  = $clog2(M)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wgtStrobes_t       strb,
  input  logic [IDX_W-1:0]  splitSlot,
  input  logic [IDX_W-1:0]  newSlot,
  input  logic [M-1:0]      effMask,
  input  logic [M-1:0]      mergeHit,
  input  logic [IDX_W-1:0]  predSlot,
  input  logic [PC_W-1:0]   predPc,
  input  logic [PC_W-1:0]   mispPc,
  input  logic [SEQ_W-1:0]  mispSeq [M],
  input  logic [PID_W-1:0]  startPid,
  input  logic [PC_W-1:0]   startPc,
  input  logic [WARP_W-1:0] warpId,
  output logic [M-1:0]      curValid,
  output logic [M-1:0]      curMask [M],
  output logic [PC_W-1:0]   curPc   [M],
  output logic [PID_W-1:0]  curPid  [M],
  output logic [SEQ_W-1:0]  curSeq  [M],
  output logic              killValid,
  output logic [M-1:0]      killMask,
  output logic [WARP_W-1:0] killWarp
);
  logic [M-1:0]     nValid;
  logic [M-1:0]     nMask [M];
  logic [PC_W-1:0]  nPc   [M];
  logic [PID_W-1:0] nPid  [M];
  logic [SEQ_W-1:0] nSeq  [M];
  logic [M-1:0]     merged;

  always_comb begin
    nValid = curValid;
    nMask  = curMask;
    nPc    = curPc;
    nPid   = curPid;
    nSeq   = curSeq;
    merged = '0;
    if (strb.startEn) begin
      nValid   = '0;
      nValid[0] = 1'b1;
      for (int s = 0; s < M; s++) begin
        nMask[s] = '0;
        nSeq[s]  = '0;
      end
      nMask[0] = '1;
      nPid[0]  = startPid;
      nPc[0]   = startPc;
    end else begin
      if (strb.splitEn) begin
        if (strb.splitTotal) begin
          nPc[splitSlot] = mispPc;
        end else begin
          nMask[splitSlot] = curMask[splitSlot] & ~effMask;
          nValid[newSlot]  = 1'b1;
          nMask[newSlot]   = effMask;
          nPc[newSlot]     = mispPc;
          nPid[newSlot]    = curPid[splitSlot];
        end
        for (int i = 0; i < M; i++)
          if (effMask[i]) nSeq[i] = mispSeq[i] + SEQ_W'(1);
      end
      if (strb.predEn) begin
        merged = nMask[predSlot];
        for (int s = 0; s < M; s++) begin
          if (mergeHit[s]) begin
            merged    = merged | curMask[s];
            nValid[s] = 1'b0;
            nMask[s]  = '0;
          end
        end
        nMask[predSlot] = merged;
        nPc[predSlot]   = predPc;
        for (int i = 0; i < M; i++)
          if (merged[i]) nSeq[i] = nSeq[i] + SEQ_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curValid  <= '0;
      killValid <= 1'b0;
      killMask  <= '0;
      killWarp  <= '0;
      for (int s = 0; s < M; s++) begin
        curMask[s] <= '0;
        curPc[s]   <= '0;
        curPid[s]  <= '0;
        curSeq[s]  <= '0;
      end
    end else begin
      curValid  <= nValid;
      curMask   <= nMask;
      curPc     <= nPc;
      curPid    <= nPid;
      curSeq    <= nSeq;
      killValid <= strb.splitEn;
      killMask  <= strb.splitEn ? effMask : '0;
      killWarp  <= warpId;
    end
  end
endmodule

// File: rtl/warp_group_tracker.sv
module warp_group_tracker
  import wgt_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 16,
  parameter int PID_W       = 4,
  parameter int SEQ_W       = 6,
  parameter int WARP_W      = 2,
  localparam int IDX_W      = $clog2(NUM_THREADS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WARP_W-1:0]            warpId,
  input  logic                         startValid,
  input  logic [PID_W-1:0]             startPid,
  input  logic [PC_W-1:0]              startPc,
  input  logic                         predValid,
  input  logic [IDX_W-1:0]             predSlot,
  input  logic [PC_W-1:0]              predPc,
  input  logic                         mispValid,
  input  logic [IDX_W-1:0]             mispSlot,
  input  logic [NUM_THREADS-1:0]       mispMask,
  input  logic [PC_W-1:0]              mispPc,
  input  logic [NUM_THREADS*SEQ_W-1:0] mispSeq,
  output logic [NUM_THREADS-1:0]       slotValid,
  output logic [NUM_THREADS*NUM_THREADS-1:0] slotMask,
  output logic [NUM_THREADS*PC_W-1:0]  slotPc,
  output logic [NUM_THREADS*PID_W-1:0] slotPid,
  output logic [NUM_THREADS*SEQ_W-1:0] seqVec,
  output logic                         killValid,
  output logic [NUM_THREADS-1:0]       killMask,
  output logic [WARP_W-1:0]            killWarp
);
  localparam int M = NUM_THREADS;

  wgtStrobes_t      strb;
  logic [IDX_W-1:0] newSlot;
  logic [M-1:0]     effMask;
  logic [M-1:0]     mergeHit;
  logic [M-1:0]     curMask [M];
  logic [PC_W-1:0]  curPc   [M];
  logic [PID_W-1:0] curPid  [M];
  logic [SEQ_W-1:0] curSeq  [M];
  logic [SEQ_W-1:0] seqIn   [M];

  for (genvar g = 0; g < M; g++) begin : g_flat
    assign seqIn[g]                  = mispSeq[g*SEQ_W +: SEQ_W];
    assign slotMask[g*M +: M]        = curMask[g];
    assign slotPc[g*PC_W +: PC_W]    = curPc[g];
    assign slotPid[g*PID_W +: PID_W] = curPid[g];
    assign seqVec[g*SEQ_W +: SEQ_W]  = curSeq[g];
  end

  wgt_ctrl #(.M(M), .PC_W(PC_W), .PID_W(PID_W), .IDX_W(IDX_W)) u_ctrl (
    .startValid(startValid), .predValid(predValid), .predSlot(predSlot),
    .predPc(predPc), .mispValid(mispValid), .mispSlot(mispSlot),
    .mispMask(mispMask), .curValid(slotValid), .curMask(curMask),
    .curPc(curPc), .curPid(curPid), .strb(strb), .newSlot(newSlot),
    .effMask(effMask), .mergeHit(mergeHit)
  );

  wgt_dp #(.M(M), .PC_W(PC_W), .PID_W(PID_W), .SEQ_W(SEQ_W),
           .WARP_W(WARP_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .splitSlot(mispSlot),
    .newSlot(newSlot), .effMask(effMask), .mergeHit(mergeHit),
    .predSlot(predSlot), .predPc(predPc), .mispPc(mispPc), .mispSeq(seqIn),
    .startPid(startPid), .startPc(startPc), .warpId(warpId),
    .curValid(slotValid), .curMask(curMask), .curPc(curPc), .curPid(curPid),
    .curSeq(curSeq), .killValid(killValid), .killMask(killMask),
    .killWarp(killWarp)
  );
endmodule

// File: rtl/wgt_chk.sv
module wgt_chk #(
  parameter int M = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           startValid,
  input logic [M-1:0]   slotValid,
  input logic [M*M-1:0] slotMask,
  input logic           killValid,
  input logic [M-1:0]   killMask
);
  logic [M-1:0] unionMask;
  logic         overlap;
  logic         validMismatch;

  always_comb begin
    unionMask     = '0;
    overlap       = 1'b0;
    validMismatch = 1'b0;
    for (int s = 0; s < M; s++) begin
      if ((unionMask & slotMask[s*M +: M]) != '0) overlap = 1'b1;
      unionMask = unionMask | slotMask[s*M +: M];
      if (slotValid[s] != (|slotMask[s*M +: M])) validMismatch = 1'b1;
    end
  end

  assert_disjoint_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !overlap);
  assert_valid_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !validMismatch);
  assert_full_cover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unionMask == '0) || (unionMask == '1));
  assert_start_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
    startValid |=> (slotValid == M'(1)) && (slotMask[M-1:0] == '1));
  assert_kill_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    killValid |-> (killMask != '0) && ((killMask & ~unionMask) == '0));
endmodule

bind warp_group_tracker wgt_chk #(.M(NUM_THREADS)) i_wgt_chk (
  .clk(clk), .rst_n(rst_n), .startValid(startValid), .slotValid(slotValid),
  .slotMask(slotMask), .killValid(killValid), .killMask(killMask)
);

// File: tb/test_warp_group_tracker.sv
module test_warp_group_tracker;
  localparam int M = 4, PC_W = 16, PID_W = 4, SEQ_W = 6, WARP_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WARP_W-1:0] warpId = 2'd2;
  logic startValid = 0; logic [PID_W-1:0] startPid = '0; logic [PC_W-1:0] startPc = '0;
  logic predValid = 0;  logic [1:0] predSlot = '0;  logic [PC_W-1:0] predPc = '0;
  logic mispValid = 0;  logic [1:0] mispSlot = '0;  logic [M-1:0] mispMask = '0;
  logic [PC_W-1:0] mispPc = '0; logic [M*SEQ_W-1:0] mispSeq = '0;
  logic [M-1:0] slotValid; logic [M*M-1:0] slotMask;
  logic [M*PC_W-1:0] slotPc; logic [M*PID_W-1:0] slotPid; logic [M*SEQ_W-1:0] seqVec;
  logic killValid; logic [M-1:0] killMask; logic [WARP_W-1:0] killWarp;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  warp_group_tracker i_warp_group_tracker (.*);

  function automatic logic [M*SEQ_W-1:0] sq(int t0, int t1, int t2, int t3);
    return {SEQ_W'(t3), SEQ_W'(t2), SEQ_W'(t1), SEQ_W'(t0)};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chkSlots(string req, logic [M-1:0] v, logic [M*M-1:0] m,
                          logic [M*SEQ_W-1:0] s);
    chk(req, "slotValid", 64'(slotValid), 64'(v));
    chk(req, "slotMask", 64'(slotMask), 64'(m));
    chk(req, "seqVec", 64'(seqVec), 64'(s));
  endtask

  function automatic logic [PC_W-1:0] pcOf(int s);
    return slotPc[s*PC_W +: PC_W];
  endfunction

  task automatic cyc();
    @(negedge clk);
    startValid = 0; predValid = 0; mispValid = 0;
  endtask

  task automatic doPred(int s, logic [PC_W-1:0] pc);
    predValid = 1; predSlot = 2'(s); predPc = pc;
  endtask

  task automatic doMisp(int s, logic [M-1:0] m, logic [PC_W-1:0] pc,
                        logic [M*SEQ_W-1:0] q);
    mispValid = 1; mispSlot = 2'(s); mispMask = m; mispPc = pc; mispSeq = q;
  endtask

  task automatic tReset();
    chkSlots("R1", 4'b0000, 16'h0000, '0);
    chk("R1", "killValid", 64'(killValid), 0);
  endtask

  task automatic tStart();
    startValid = 1; startPid = 4'd3; startPc = 16'h0100;
    doPred(2, 16'h0999);  // start has priority over a prediction
    cyc();
    chkSlots("R2", 4'b0001, 16'h000F, '0);
    chk("R2", "pc0", 64'(pcOf(0)), 64'h100);
    chk("R2", "pid0", 64'(slotPid[3:0]), 3);
  endtask

  task automatic tPredNoMatch();
    doPred(0, 16'h0104); cyc();
    chkSlots("R3", 4'b0001, 16'h000F, sq(1, 1, 1, 1));
    chk("R3", "pc0", 64'(pcOf(0)), 64'h104);
    doPred(3, 16'h0abc); cyc();  // invalid slot: no effect
    chkSlots("R3", 4'b0001, 16'h000F, sq(1, 1, 1, 1));
  endtask

  task automatic tPartialSplit();
    doMisp(0, 4'b0101, 16'h0200, sq(1, 1, 1, 1)); cyc();
    chkSlots("R5", 4'b0011, 16'h005A, sq(2, 1, 2, 1));
    chk("R5", "pc1", 64'(pcOf(1)), 64'h200);
    chk("R5", "pid1", 64'(slotPid[7:4]), 3);
    chk("R7", "killValid", 64'(killValid), 1);
    chk("R7", "killMask", 64'(killMask), 64'b0101);
    chk("R7", "killWarp", 64'(killWarp), 2);
    cyc();
    chk("R7", "killValid drops", 64'(killValid), 0);
  endtask

  task automatic tMerge();
    doPred(0, 16'h0108); cyc();
    chkSlots("R3", 4'b0011, 16'h005A, sq(2, 2, 2, 2));
    doPred(1, 16'h0108); cyc();
    chkSlots("R4", 4'b0010, 16'h00F0, sq(3, 3, 3, 3));
    chk("R4", "pc1", 64'(pcOf(1)), 64'h108);
  endtask

  task automatic tTotalSplit();
    doMisp(1, 4'b1111, 16'h0300, sq(3, 3, 3, 3)); cyc();
    chkSlots("R6", 4'b0010, 16'h00F0, sq(4, 4, 4, 4));
    chk("R6", "pc1", 64'(pcOf(1)), 64'h300);
    chk("R7", "killMask total", 64'(killMask), 64'hF);
    cyc();
    doMisp(0, 4'b1111, 16'h0777, sq(9, 9, 9, 9)); cyc();  // invalid slot
    chkSlots("R7", 4'b0010, 16'h00F0, sq(4, 4, 4, 4));
    chk("R7", "no kill on invalid slot", 64'(killValid), 0);
  endtask

  task automatic tSameCycle();
    doMisp(1, 4'b0011, 16'h0400, sq(4, 4, 4, 4)); cyc();
    chkSlots("R5", 4'b0011, 16'h00C3, sq(5, 5, 4, 4));
    chk("R5", "pc0 lowest free", 64'(pcOf(0)), 64'h400);
    doMisp(1, 4'b1000, 16'h0500, sq(4, 4, 4, 4));
    doPred(0, 16'h0500); cyc();
    chkSlots("R8", 4'b0111, 16'h0843, sq(6, 6, 4, 5));
    chk("R8", "pc0", 64'(pcOf(0)), 64'h500);
    chk("R8", "pc2", 64'(pcOf(2)), 64'h500);
    doPred(0, 16'h0500); cyc();
    chkSlots("R4", 4'b0011, 16'h004B, sq(7, 7, 4, 6));
    doMisp(1, 4'b0100, 16'h0600, sq(9, 9, 9, 9));
    doPred(1, 16'h0700); cyc();
    chkSlots("R8", 4'b0011, 16'h004B, sq(7, 7, 10, 6));
    chk("R8", "pc1 redirect wins", 64'(pcOf(1)), 64'h600);
    chk("R7", "killMask", 64'(killMask), 64'b0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1;
    tStart();
    tPredNoMatch();
    tPartialSplit();
    tMerge();
    tTotalSplit();
    tSameCycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule